// File: doc/BRIEF.md
# ARINC 429 Receive Channel

This block receives one ARINC 429 serial channel whose differential line has already been turned into two logic-level signals. One signal is high while the line carries a "one" and the other is high while it carries a "zero". The block oversamples the pair at ten samples per bit. It accepts a bit only when the pair shows a clean level for several samples in a row. It assembles either a 32-bit or a 25-bit word. A long null on the line throws away a partly received word.

A finished word can be screened by comparing its source/destination field with two configured bits. The block then computes its parity status and copies it into a holding register, which raises a ready flag. A host fetches the word as two 16-bit halves through a select line and a read strobe. The strobe that reads the upper half drops the ready flag. For self-test, a select input swaps the line pair for a loopback pair taken from a local transmitter.

Top module: `a429_rx_chan`

## Requirements
- R1: With `rate_low_i`=0 the line pair is sampled on every clock. With `rate_low_i`=1 it is sampled once every 8 clocks, which gives the low bit rate at the same 10 samples per bit.
- R2: A bit is taken when exactly one of the two line signals is high for 3 consecutive samples. Only one bit is taken per pulse. Shorter pulses, nulls (both low) and both-high samples add no bit.
- R3: `word25_i`=0 selects 32-bit words and `word25_i`=1 selects 25-bit words. The first received bit is stored in holding bit 0, and the following bits go into ascending positions. In 25-bit mode, holding bits 31..25 are zero.
- R4: After more than 20 consecutive null samples, any partial word is dropped. The next bit then starts a new word at bit 0, and a dropped word never raises `ready_o`.
- R5: With `sd_en_i`=1 in 32-bit mode, a word is accepted only if holding bit 8 equals `sd_x_i` and holding bit 9 equals `sd_y_i`. These are the word's 9th and 10th received bits. Any other word is discarded: the holding register and `ready_o` are left unchanged.
- R6: In 25-bit mode the source/destination check is skipped.
- R7: An accepted word is copied into the holding register and `ready_o` is set. A word that has not been read is overwritten by the next accepted word.
- R8: The parity status is 1 when the stored word has an even number of ones and 0 when the number is odd. It appears on `rd_data_o[8]` of the lower half.
- R9: While `rd_en_i`=1, `sel_i`=0 drives the lower half {hold[14:8], parity status, hold[7:0]}, and `sel_i`=1 drives the upper half hold[30:15]. `rd_data_o` is 0 while `rd_en_i`=0. The halves can be read in any order and any number of times.
- R10: The rising edge of `rd_en_i` with `sel_i`=1 clears `ready_o`. A read with `sel_i`=0 leaves it set. A word accepted in the same cycle as that edge wins, and `ready_o` stays set.
- R11: With `self_test_i`=1 the receiver takes its input from `lb_one_i`/`lb_zero_i` and ignores the line pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock, ten times the high bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_low_i | input | 1 | 1 selects the low bit rate (sampling every 8 clocks) |
| word25_i | input | 1 | 1 selects the 25-bit word format |
| sd_en_i | input | 1 | Enables the source/destination filter |
| sd_x_i | input | 1 | Value required at holding bit 8 |
| sd_y_i | input | 1 | Value required at holding bit 9 |
| self_test_i | input | 1 | 1 selects the loopback pair as input |
| line_one_i | input | 1 | Line carries a one |
| line_zero_i | input | 1 | Line carries a zero |
| lb_one_i | input | 1 | Loopback one signal |
| lb_zero_i | input | 1 | Loopback zero signal |
| sel_i | input | 1 | Half select: 0 lower, 1 upper |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Selected half while the strobe is high, else 0 |
| ready_o | output | 1 | An accepted word is waiting |

## Verification
A wrong bit count or shift position cannot be hidden at the ports. The next word read back comes out rotated or split across two words, as soon as the first word after the fault is fetched. The same applies to a gap counter that never clears a partial word. A bad run counter or sampling divider either loses every word or duplicates bits, which shows up within one word time. A faulty filter or ready flag shows up on the very next read strobe: the wrong word is latched, or `ready_o` is set or cleared when it should not be.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int unsigned WORD_MAX = 32;
  localparam int unsigned HALF_W   = 16;

  typedef struct packed {
    logic word25;
    logic sd_en;
    logic sd_x;
    logic sd_y;
  } rx_cfg_t;
endpackage

// File: rtl/a429_rate_tick.sv
module a429_rate_tick #(
  parameter int unsigned LOW_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_low_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(LOW_DIV > 1 ? LOW_DIV : 2);
  localparam logic [CW-1:0] LAST = CW'(LOW_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = !rate_low_i || (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1
  low_rate_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LOW_DIV > 1 && rate_low_i && tick_o) |=> (!tick_o || !rate_low_i));
endmodule

// File: rtl/a429_bit_slicer.sv
module a429_bit_slicer #(
  parameter int unsigned VALID_RUN = 3,
  parameter int unsigned GAP_LIMIT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic one_i,
  input  logic zero_i,
  output logic bit_v_o,
  output logic bit_o,
  output logic gap_o
);
  localparam int unsigned RW = $clog2(VALID_RUN + 1);
  localparam int unsigned GW = $clog2(GAP_LIMIT + 2);
  localparam logic [RW-1:0] RUN_TAKE = RW'(VALID_RUN - 1);
  localparam logic [RW-1:0] RUN_SAT  = RW'(VALID_RUN);
  localparam logic [GW-1:0] GAP_FIRE = GW'(GAP_LIMIT);
  localparam logic [GW-1:0] GAP_SAT  = GW'(GAP_LIMIT + 1);

  logic [1:0] s1_q, s2_q;
  logic [RW-1:0] run_q;
  logic [GW-1:0] gap_q;
  logic prev_q;
  logic is_one, is_zero, is_null, same;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= {one_i, zero_i};
      s2_q <= s1_q;
    end
  end

  assign is_one  = s2_q[1] & ~s2_q[0];
  assign is_zero = s2_q[0] & ~s2_q[1];
  assign is_null = ~(is_one | is_zero);
  assign same    = (run_q != '0) && (prev_q == is_one);

  assign bit_v_o = tick_i && !is_null && same && (run_q == RUN_TAKE);
  assign bit_o   = is_one;
  assign gap_o   = tick_i && is_null && (gap_q == GAP_FIRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      gap_q  <= '0;
      prev_q <= 1'b0;
    end else if (tick_i) begin
      if (is_null) begin
        run_q <= '0;
        if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
      end else begin
        gap_q  <= '0;
        prev_q <= is_one;
        if (!same)                run_q <= RW'(1);
        else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
      end
    end
  end

  // R2
  one_bit_per_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_v_o |=> !bit_v_o);
endmodule

// File: rtl/a429_word_asm.sv
module a429_word_asm
  import a429_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_v_i,
  input  logic                bit_i,
  input  logic                gap_i,
  input  rx_cfg_t             cfg_i,
  output logic                done_o,
  output logic                accept_o,
  output logic [WORD_MAX-1:0] word_o
);
  localparam int unsigned CW = $clog2(WORD_MAX + 1);

  logic [CW-1:0]       cnt_q, len;
  logic [WORD_MAX-1:0] sr_q, nxt;
  logic                last, sd_ok;

  assign len  = cfg_i.word25 ? CW'(25) : CW'(WORD_MAX);
  assign last = bit_v_i && (cnt_q >= len - 1'b1);

  always_comb begin
    nxt = sr_q;
    nxt[cnt_q[$clog2(WORD_MAX)-1:0]] = bit_i;
  end

  // filter on the 9th/10th received bits, 32-bit format only
  assign sd_ok = !cfg_i.sd_en || cfg_i.word25 ||
                 (nxt[8] == cfg_i.sd_x && nxt[9] == cfg_i.sd_y);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sr_q     <= '0;
      done_o   <= 1'b0;
      accept_o <= 1'b0;
      word_o   <= '0;
    end else begin
      done_o   <= last;
      accept_o <= last && sd_ok;
      if (last) word_o <= nxt;
      if (gap_i || last) begin
        cnt_q <= '0;
        sr_q  <= '0;
      end else if (bit_v_i) begin
        cnt_q <= cnt_q + 1'b1;
        sr_q  <= nxt;
      end
    end
  end

  // R3
  count_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(WORD_MAX));
  // R4
  gap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_i |=> (cnt_q == '0));
endmodule

// File: rtl/a429_rx_chan.sv
module a429_rx_chan
  import a429_rx_pkg::*;
#(
  parameter int unsigned LOW_DIV   = 8,
  parameter int unsigned VALID_RUN = 3,
  parameter int unsigned GAP_LIMIT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_low_i,
  input  logic              word25_i,
  input  logic              sd_en_i,
  input  logic              sd_x_i,
  input  logic              sd_y_i,
  input  logic              self_test_i,
  input  logic              line_one_i,
  input  logic              line_zero_i,
  input  logic              lb_one_i,
  input  logic              lb_zero_i,
  input  logic              sel_i,
  input  logic              rd_en_i,
  output logic [HALF_W-1:0] rd_data_o,
  output logic              ready_o
);
  rx_cfg_t             cfg;
  logic                tick, src_one, src_zero;
  logic                bit_v, bit_val, gap;
  logic                wd_done, wd_accept;
  logic [WORD_MAX-1:0] wd_word, hold_q;
  logic                ready_q, rd_en_q, rd_rise, par_even;
  logic [HALF_W-1:0]   lo_half, hi_half;

  assign cfg      = '{word25: word25_i, sd_en: sd_en_i, sd_x: sd_x_i, sd_y: sd_y_i};
  assign src_one  = self_test_i ? lb_one_i  : line_one_i;
  assign src_zero = self_test_i ? lb_zero_i : line_zero_i;

  a429_rate_tick #(.LOW_DIV(LOW_DIV)) u_tick (
    .clk_i, .rst_ni, .rate_low_i, .tick_o(tick)
  );

  a429_bit_slicer #(.VALID_RUN(VALID_RUN), .GAP_LIMIT(GAP_LIMIT)) u_slice (
    .clk_i, .rst_ni, .tick_i(tick), .one_i(src_one), .zero_i(src_zero),
    .bit_v_o(bit_v), .bit_o(bit_val), .gap_o(gap)
  );

  a429_word_asm u_asm (
    .clk_i, .rst_ni, .bit_v_i(bit_v), .bit_i(bit_val), .gap_i(gap), .cfg_i(cfg),
    .done_o(wd_done), .accept_o(wd_accept), .word_o(wd_word)
  );

  assign rd_rise = rd_en_i && !rd_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      ready_q <= 1'b0;
      rd_en_q <= 1'b0;
    end else begin
      rd_en_q <= rd_en_i;
      if (wd_done && wd_accept) begin
        hold_q  <= wd_word;
        ready_q <= 1'b1;
      end else if (rd_rise && sel_i) begin
        ready_q <= 1'b0;
      end
    end
  end

  assign par_even  = ~^hold_q;
  assign lo_half   = {hold_q[14:8], par_even, hold_q[7:0]};
  assign hi_half   = hold_q[30:15];
  assign rd_data_o = rd_en_i ? (sel_i ? hi_half : lo_half) : '0;
  assign ready_o   = ready_q;

  // R7
  ready_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(wd_done && wd_accept));
  // R5
  reject_keeps_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_done && !wd_accept) |=> $stable(hold_q));
  // R10
  low_read_keeps_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && !sel_i && ready_q) |=> ready_q);
endmodule

// File: tb/tb_a429_rx_chan.sv
module tb_a429_rx_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rate_low = 0, word25 = 0, sd_en = 0, sd_x = 0, sd_y = 0, self_test = 0;
  logic one_s = 0, zero_s = 0, route_lb = 0, sel = 0, rd_en = 0;
  logic line_one, line_zero, lb_one, lb_zero;
  logic [15:0] rd_data;
  logic ready;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  // when routed to loopback, the line carries inverted data as a decoy
  assign line_one  = route_lb ? zero_s : one_s;
  assign line_zero = route_lb ? one_s  : zero_s;
  assign lb_one    = route_lb ? one_s  : 1'b0;
  assign lb_zero   = route_lb ? zero_s : 1'b0;

  a429_rx_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .rate_low_i(rate_low), .word25_i(word25),
    .sd_en_i(sd_en), .sd_x_i(sd_x), .sd_y_i(sd_y), .self_test_i(self_test),
    .line_one_i(line_one), .line_zero_i(line_zero), .lb_one_i(lb_one),
    .lb_zero_i(lb_zero), .sel_i(sel), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .ready_o(ready)
  );

  // {data[31:0], word25, sd_en, x, y, accept}
  localparam logic [36:0] VEC [6] = '{
    {32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'h8000_0301, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {32'h0000_0201, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'hCAFE_0100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {32'h01AB_CDEF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  function automatic logic [31:0] msk(logic [31:0] d, logic w25);
    return w25 ? (d & 32'h01FF_FFFF) : d;
  endfunction
  function automatic logic [15:0] lo_of(logic [31:0] m);
    return {m[14:8], ($countones(m) % 2 == 0) ? 1'b1 : 1'b0, m[7:0]};
  endfunction
  function automatic logic [15:0] hi_of(logic [31:0] m);
    return m[30:15];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic o, logic z, int n);
    int spc = rate_low ? 8 : 1;
    one_s = o; zero_s = z;
    repeat (n * spc) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    drive(b, !b, 5);
    drive(1'b0, 1'b0, 5);
  endtask

  task automatic send_bits(logic [31:0] d, int len);
    for (int i = 0; i < len; i++) send_bit(d[i]);
  endtask

  task automatic send_word(logic [31:0] d, int len);
    send_bits(d, len);
    drive(1'b0, 1'b0, 40);
  endtask

  task automatic read_half(logic s, output logic [15:0] v);
    @(negedge clk); sel = s; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_word(string tag, logic [31:0] m);
    logic [15:0] v;
    read_half(1'b0, v); check({tag, " lo"}, 32'(v), 32'(lo_of(m)));
    read_half(1'b1, v); check({tag, " hi"}, 32'(v), 32'(hi_of(m)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] last_acc;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    check("R7 reset ready", 32'(ready), 0);
    check("R9 idle bus zero", 32'(rd_data), 0);
    rst_n = 1'b1;
    drive(0, 0, 30);
    read_half(1'b0, v);
    check("R8 reset lo half", 32'(v), 32'h0100);
    last_acc = '0;

    // table walk: R3 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 6; i++) begin
      logic [36:0] e = VEC[i];
      logic [31:0] m = msk(e[36:5], e[4]);
      word25 = e[4]; sd_en = e[3]; sd_x = e[2]; sd_y = e[1];
      read_half(1'b1, v);
      send_word(e[36:5], e[4] ? 25 : 32);
      check($sformatf("R5 R6 vec%0d ready", i), 32'(ready), 32'(e[0]));
      if (e[0]) last_acc = m;
      read_word($sformatf("R3 R8 R9 vec%0d", i), last_acc);
      check($sformatf("R10 vec%0d cleared", i), 32'(ready), 0);
    end
    word25 = 0; sd_en = 0;

    // R10: lower read keeps flag, upper read clears; R9 any order, repeated
    send_word(32'h0F0F_3C3C, 32);
    read_half(1'b0, v); check("R10 lo keeps ready", 32'(ready), 1);
    read_half(1'b1, v); check("R9 hi first", 32'(v), 32'(hi_of(32'h0F0F_3C3C)));
    check("R10 hi clears ready", 32'(ready), 0);
    read_half(1'b0, v); check("R9 lo repeat", 32'(v), 32'(lo_of(32'h0F0F_3C3C)));
    read_half(1'b0, v); check("R9 lo repeat2", 32'(v), 32'(lo_of(32'h0F0F_3C3C)));

    // R7: unread word overwritten
    send_word(32'hAAAA_0001, 32);
    send_word(32'h5555_8002, 32);
    check("R7 ready after two", 32'(ready), 1);
    read_word("R7 overwrite", 32'h5555_8002);

    // R4: partial word alone gives nothing
    send_bits(32'hFFFF_FFFF, 10);
    drive(0, 0, 30);
    check("R4 partial no ready", 32'(ready), 0);
    // R4: partial then full word decodes cleanly
    send_bits(32'hFFFF_FFFF, 10);
    drive(0, 0, 30);
    send_word(32'h1357_9BDF, 32);
    check("R4 ready after restart", 32'(ready), 1);
    read_word("R4 restart word", 32'h1357_9BDF);

    // R2: short 2-sample pulses are not bits
    drive(1, 0, 2); drive(0, 0, 5);
    drive(0, 1, 2); drive(0, 0, 5);
    send_word(32'h2468_ACE0, 32);
    read_word("R2 short pulses", 32'h2468_ACE0);

    // R1: low rate word
    rate_low = 1;
    send_word(32'h5A5A_A5A5, 32);
    check("R1 low rate ready", 32'(ready), 1);
    read_word("R1 low rate word", 32'h5A5A_A5A5);
    // R1: fast-rate bits at low sampling are not recovered
    rate_low = 0;
    for (int i = 0; i < 32; i++) begin
      one_s = 1; zero_s = 0; repeat (2) @(negedge clk);
      one_s = 0; repeat (5) @(negedge clk);
      rate_low = 1; zero_s = 1; rate_low = 1;
      one_s = 0; repeat (2) @(negedge clk);
      zero_s = 0; repeat (5) @(negedge clk);
    end
    drive(0, 0, 30);
    check("R1 no bits at wrong rate", 32'(ready), 0);
    rate_low = 0;
    drive(0, 0, 30);

    // R11: loopback selected, line carries inverted decoy
    self_test = 1; route_lb = 1;
    send_word(32'hC0DE_1234, 32);
    check("R11 ready", 32'(ready), 1);
    read_word("R11 loopback word", 32'hC0DE_1234);
    self_test = 0; route_lb = 0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule